// File: doc/BRIEF.md
# Flash Bank Erase and Program Sequencer

This block drives a byte-wide flash device that takes commands over a plain 8-bit bus. The bus carries an address, write data, a write strobe, a read strobe and read data. The block works on one bank at a time. It either erases the bank or programs every byte of it from an image buffer. The image buffer is read through a combinational byte port.

Each device operation follows the same steps. The block issues a command pair, then reads the device status register until the ready bit appears. It checks the fault bits and always ends with a reset command. When no fault was reported, it reads the whole bank back and compares each byte against its expected value. A poll limit set by the host turns a device that never reports ready into a failure.

The host pulses `start` with an operation select and a bank index. It then waits for `done`. When `done` is high, `fail` gives the verdict and `status_q` holds the status byte that ended the last poll.

Top module: `flash_bank_seq`

## Requirements
- R1: An erase writes 0x20 and then 0xD0 on consecutive cycles, both to the bank base address, which is bank × BANK_BYTES.
- R2: After each command pair, the block reads at the bank base once per cycle (read strobe high, read data taken in the same cycle) until status bit 7 is set. The write and read strobes are never high together.
- R3: When bit 7 is seen together with any of bits 5:3 (mask 0x38), the operation fails and `status_q` holds that byte. On a passing operation, `status_q` has bit 7 set and bits 5:3 clear.
- R4: Every time polling ends, whether it passed or failed, 0xFF is written once to the bank base before `done` rises.
- R5: After a clean erase, every byte of the bank is read back in ascending order. Any byte other than 0xFF makes the operation fail.
- R6: A program visits the bytes in ascending offset order. For each byte it writes 0x40 and then the image byte to that byte's address on consecutive cycles, then polls at the bank base.
- R7: Programming stops at the first byte whose status shows a fault. No later byte receives a program command.
- R8: After a clean program, every byte is read back. Any byte that differs from the image makes the operation fail.
- R9: If bit 7 is still clear after `timeout_lim` consecutive status reads (a value of 0 counts as 1), the operation fails and `status_q` holds the last status read.
- R10: A `start` pulse while idle begins an operation, and `busy` is high on the next cycle. `done` and `fail` then stay stable until the next accepted start. A `start` while busy is ignored.
- R11: After reset, `busy`, `done`, `fail`, both strobes and `status_q` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| op_prog | input | 1 | 1 = program bank from image, 0 = erase bank |
| bank | input | BANK_W | Bank index |
| timeout_lim | input | TO_W | Maximum status reads per poll |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last operation finished; held until next start |
| fail | output | 1 | Last operation failed (valid with done) |
| status_q | output | 8 | Status byte that ended the last poll |
| fl_addr | output | ADDR_W | Flash byte address |
| fl_wdata | output | 8 | Flash write data / command |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | 8 | Flash read data, valid in the strobe cycle |
| img_addr | output | OFS_W | Image buffer byte offset |
| img_data | input | 8 | Image buffer byte at img_addr |

## Verification
The bench sweeps every bank of a small four-bank, 16-byte configuration, using arithmetic patterns and a behavioural device model that logs each command. The corner cases it goes after are these:
- A fault on byte 5. A design that kept going would show more than six program commands.
- A device that never becomes ready. A wrong limit would show a read count other than the limit.
- A stuck erased byte and a corrupted programmed byte. A design that skipped readback would report a pass.
- A start pulse during an operation. A design that accepted it would alter a second bank.

It also checks two things. Polling stays at the bank base, so an offset slip would be counted. The reset command appears exactly once per operation, so a missing reset would be caught.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_CMD1 = 3'd1,
        ST_CMD2 = 3'd2,
        ST_POLL = 3'd3,
        ST_RST  = 3'd4,
        ST_VFY  = 3'd5
    } fsq_state_e;

    typedef enum logic {
        FSQ_ERASE = 1'b0,
        FSQ_PROG  = 1'b1
    } fsq_op_e;

    localparam logic [7:0] FL_ERASE_SETUP = 8'h20;
    localparam logic [7:0] FL_ERASE_GO    = 8'hD0;
    localparam logic [7:0] FL_PROG_SETUP  = 8'h40;
    localparam logic [7:0] FL_RESET       = 8'hFF;
    localparam logic [7:0] FL_ERASED      = 8'hFF;
    localparam logic [7:0] FL_READY_MASK  = 8'h80;
    localparam logic [7:0] FL_FAULT_MASK  = 8'h38;

    function automatic logic fl_ready(input logic [7:0] s);
        return (s & FL_READY_MASK) != 8'h00;
    endfunction

    function automatic logic fl_fault(input logic [7:0] s);
        return (s & FL_FAULT_MASK) != 8'h00;
    endfunction

endpackage

// File: rtl/fsq_walker.sv
module fsq_walker #(
    parameter int OFS_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    output logic [OFS_W-1:0] ofs,
    output logic             last
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            ofs <= '0;
        else if (adv)
            ofs <= ofs + 1'b1;
    end

    assign last = &ofs;
endmodule

// File: rtl/fsq_poll_watch.sv
module fsq_poll_watch #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            polling,
    input  logic [TO_W-1:0] lim,
    output logic            expire
);
    logic [TO_W-1:0] cnt;
    logic [TO_W:0]   reads_so_far;

    always_ff @(posedge clk) begin
        if (rst || !polling)
            cnt <= '0;
        else if (cnt != {TO_W{1'b1}})
            cnt <= cnt + 1'b1;
    end

    assign reads_so_far = {1'b0, cnt} + {{TO_W{1'b0}}, 1'b1};
    assign expire       = polling && (reads_so_far >= {1'b0, lim});
endmodule

// File: rtl/fsq_bus_drive.sv
module fsq_bus_drive
    import fsq_pkg::*;
#(
    parameter int OFS_W  = 13,
    parameter int BANK_W = 1,
    localparam int ADDR_W = OFS_W + BANK_W
) (
    input  fsq_state_e        st,
    input  fsq_op_e           op,
    input  logic [BANK_W-1:0] bank,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [7:0]        img_byte,
    output logic [ADDR_W-1:0] addr,
    output logic [7:0]        wdata,
    output logic              we,
    output logic              re
);
    logic [ADDR_W-1:0] base_addr;
    logic [ADDR_W-1:0] byte_addr;
    logic              is_prog;

    assign base_addr = {bank, {OFS_W{1'b0}}};
    assign byte_addr = {bank, ofs};
    assign is_prog   = (op == FSQ_PROG);

    always_comb begin
        addr  = base_addr;
        wdata = 8'h00;
        we    = 1'b0;
        re    = 1'b0;
        unique case (st)
            ST_CMD1: begin
                we    = 1'b1;
                addr  = is_prog ? byte_addr : base_addr;
                wdata = is_prog ? FL_PROG_SETUP : FL_ERASE_SETUP;
            end
            ST_CMD2: begin
                we    = 1'b1;
                addr  = is_prog ? byte_addr : base_addr;
                wdata = is_prog ? img_byte : FL_ERASE_GO;
            end
            ST_POLL: begin
                re   = 1'b1;
                addr = base_addr;
            end
            ST_RST: begin
                we    = 1'b1;
                addr  = base_addr;
                wdata = FL_RESET;
            end
            ST_VFY: begin
                re   = 1'b1;
                addr = byte_addr;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/flash_bank_seq.sv
module flash_bank_seq
    import fsq_pkg::*;
#(
    parameter int BANK_BYTES = 8192,
    parameter int BANKS      = 2,
    parameter int TO_W       = 16,
    localparam int OFS_W  = $clog2(BANK_BYTES),
    localparam int BANK_W = $clog2(BANKS),
    localparam int ADDR_W = OFS_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              op_prog,
    input  logic [BANK_W-1:0] bank,
    input  logic [TO_W-1:0]   timeout_lim,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [7:0]        status_q,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_wdata,
    output logic              fl_we,
    output logic              fl_re,
    input  logic [7:0]        fl_rdata,
    output logic [OFS_W-1:0]  img_addr,
    input  logic [7:0]        img_data
);
    fsq_state_e        st;
    fsq_op_e           op_q;
    logic [BANK_W-1:0] bank_q;
    logic              fail_pend;
    logic [OFS_W-1:0]  ofs;
    logic              last;
    logic              walk_clr;
    logic              walk_adv;
    logic              expire;
    logic              accept;
    logic [7:0]        expect_byte;
    logic              rd_ready;
    logic              rd_fault;

    assign accept      = start && (st == ST_IDLE);
    assign rd_ready    = fl_ready(fl_rdata);
    assign rd_fault    = fl_fault(fl_rdata);
    assign expect_byte = (op_q == FSQ_PROG) ? img_data : FL_ERASED;
    assign busy        = (st != ST_IDLE);
    assign img_addr    = ofs;

    // Offset walker: cleared on accept and on entry to readback.
    assign walk_clr = accept || (st == ST_RST);
    assign walk_adv = ((st == ST_POLL) && rd_ready && !rd_fault &&
                       (op_q == FSQ_PROG) && !last) ||
                      ((st == ST_VFY) && (fl_rdata == expect_byte) && !last);

    fsq_walker #(.OFS_W(OFS_W)) u_walker (
        .clk  (clk),
        .rst  (rst),
        .clr  (walk_clr),
        .adv  (walk_adv),
        .ofs  (ofs),
        .last (last)
    );

    fsq_poll_watch #(.TO_W(TO_W)) u_poll_watch (
        .clk     (clk),
        .rst     (rst),
        .polling (st == ST_POLL),
        .lim     (timeout_lim),
        .expire  (expire)
    );

    fsq_bus_drive #(.OFS_W(OFS_W), .BANK_W(BANK_W)) u_bus_drive (
        .st       (st),
        .op       (op_q),
        .bank     (bank_q),
        .ofs      (ofs),
        .img_byte (img_data),
        .addr     (fl_addr),
        .wdata    (fl_wdata),
        .we       (fl_we),
        .re       (fl_re)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            op_q      <= FSQ_ERASE;
            bank_q    <= '0;
            fail_pend <= 1'b0;
            done      <= 1'b0;
            fail      <= 1'b0;
            status_q  <= 8'h00;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (accept) begin
                        op_q      <= op_prog ? FSQ_PROG : FSQ_ERASE;
                        bank_q    <= bank;
                        fail_pend <= 1'b0;
                        done      <= 1'b0;
                        fail      <= 1'b0;
                        status_q  <= 8'h00;
                        st        <= ST_CMD1;
                    end
                end
                ST_CMD1: st <= ST_CMD2;
                ST_CMD2: st <= ST_POLL;
                ST_POLL: begin
                    if (rd_ready) begin
                        status_q <= fl_rdata;
                        if (rd_fault) begin
                            fail_pend <= 1'b1;
                            st        <= ST_RST;
                        end else if ((op_q == FSQ_PROG) && !last) begin
                            st <= ST_CMD1;
                        end else begin
                            st <= ST_RST;
                        end
                    end else if (expire) begin
                        status_q  <= fl_rdata;
                        fail_pend <= 1'b1;
                        st        <= ST_RST;
                    end
                end
                ST_RST: begin
                    if (fail_pend) begin
                        done <= 1'b1;
                        fail <= 1'b1;
                        st   <= ST_IDLE;
                    end else begin
                        st <= ST_VFY;
                    end
                end
                ST_VFY: begin
                    if (fl_rdata != expect_byte) begin
                        done <= 1'b1;
                        fail <= 1'b1;
                        st   <= ST_IDLE;
                    end else if (last) begin
                        done <= 1'b1;
                        st   <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fsq_checker.sv
module fsq_checker #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              op_prog,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic [7:0]        status_q,
    input logic [ADDR_W-1:0] fl_addr,
    input logic [7:0]        fl_wdata,
    input logic              fl_we,
    input logic              fl_re
);
    logic prog_q;
    logic prev_re;
    logic saw_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_q  <= 1'b0;
            prev_re <= 1'b0;
            saw_rst <= 1'b0;
        end else begin
            prev_re <= fl_re;
            if (start && !busy) begin
                prog_q  <= op_prog;
                saw_rst <= 1'b0;
            end else if (fl_we && fl_wdata == 8'hFF && prev_re) begin
                saw_rst <= 1'b1;
            end
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(fl_we && fl_re)); // R2

    AST_ERASE_PAIR: assert property (@(posedge clk) disable iff (rst)
        (fl_we && !prog_q && busy && fl_wdata == 8'hD0) |->
        ($past(fl_we) && $past(fl_wdata) == 8'h20 && $past(fl_addr) == fl_addr)); // R1

    AST_PROG_PAIR: assert property (@(posedge clk) disable iff (rst)
        (fl_we && prog_q && busy && fl_wdata == 8'h40 && !$past(fl_we)) |=>
        (fl_we && fl_addr == $past(fl_addr))); // R6

    AST_RESET_BEFORE_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> saw_rst); // R4

    AST_PASS_STATUS: assert property (@(posedge clk) disable iff (rst)
        ($rose(done) && !fail) |-> (status_q[7] && status_q[5:3] == 3'b000)); // R3

    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy); // R10

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R10

    AST_DONE_HELD: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(fail))); // R10
endmodule

bind flash_bank_seq fsq_checker #(.ADDR_W(ADDR_W)) u_fsq_checker (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .op_prog  (op_prog),
    .busy     (busy),
    .done     (done),
    .fail     (fail),
    .status_q (status_q),
    .fl_addr  (fl_addr),
    .fl_wdata (fl_wdata),
    .fl_we    (fl_we),
    .fl_re    (fl_re)
);

// File: tb/test_flash_bank_seq.sv
module test_flash_bank_seq;
    localparam int BB   = 16;
    localparam int NB   = 4;
    localparam int TOW  = 8;
    localparam int DLY  = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       op_prog = 1'b0;
    logic [1:0] bank = '0;
    logic [TOW-1:0] timeout_lim = 8'd50;
    logic       busy, done, fail;
    logic [7:0] status_q;
    logic [5:0] fl_addr;
    logic [7:0] fl_wdata, fl_rdata;
    logic       fl_we, fl_re;
    logic [3:0] img_addr;
    logic [7:0] img_data;

    always #10 clk = ~clk;

    flash_bank_seq #(.BANK_BYTES(BB), .BANKS(NB), .TO_W(TOW)) i_flash_bank_seq (
        .clk(clk), .rst(rst), .start(start), .op_prog(op_prog), .bank(bank),
        .timeout_lim(timeout_lim), .busy(busy), .done(done), .fail(fail),
        .status_q(status_q), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata),
        .img_addr(img_addr), .img_data(img_data)
    );

    // Image buffer
    logic [7:0] img [0:BB-1];
    assign img_data = img[img_addr];

    // Behavioural flash model
    logic [7:0] fm [0:BB*NB-1];
    logic [1:0] pend;
    logic       smode;
    int         busy_cnt;
    logic [7:0] errbits;
    logic [1:0] cur_bank;
    int f_err_byte = -1, f_stuck = -1, f_corrupt = -1;
    logic f_erase_err = 1'b0, f_hang = 1'b0;
    int n_prog, n_resets, n_stat_reads, bad_poll, addr_err, order_err, next_off;
    logic clr_ctr = 1'b0;

    assign fl_rdata = smode ? ((busy_cnt != 0) ? 8'h00 : (8'h80 | errbits))
                            : fm[fl_addr];

    always @(posedge clk) begin
        if (rst) begin
            pend <= 2'd0; smode <= 1'b0; busy_cnt <= 0; errbits <= 8'h00;
        end else begin
            if (busy_cnt > 0 && !f_hang) busy_cnt <= busy_cnt - 1;
            if (fl_re && smode) begin
                n_stat_reads <= n_stat_reads + 1;
                if (fl_addr != {cur_bank, 4'h0}) bad_poll <= bad_poll + 1;
            end
            if (fl_we) begin
                if (pend == 2'd1) begin
                    pend <= 2'd0;
                    if (fl_wdata == 8'hD0) begin
                        if (fl_addr != {cur_bank, 4'h0}) addr_err <= addr_err + 1;
                        for (int i = 0; i < BB; i++)
                            fm[{fl_addr[5:4], i[3:0]}] <= (i == f_stuck) ? 8'h00 : 8'hFF;
                        busy_cnt <= DLY;
                        errbits  <= f_erase_err ? 8'h08 : 8'h00;
                    end
                end else if (pend == 2'd2) begin
                    pend   <= 2'd0;
                    n_prog <= n_prog + 1;
                    if (fl_addr != {cur_bank, next_off[3:0]} || next_off >= BB)
                        order_err <= order_err + 1;
                    next_off <= next_off + 1;
                    fm[fl_addr] <= (int'(fl_addr[3:0]) == f_corrupt) ? (fl_wdata ^ 8'h01) : fl_wdata;
                    busy_cnt <= DLY;
                    errbits  <= (int'(fl_addr[3:0]) == f_err_byte) ? 8'h10 : 8'h00;
                end else begin
                    case (fl_wdata)
                        8'h20: begin
                            pend <= 2'd1; smode <= 1'b1;
                            if (fl_addr != {cur_bank, 4'h0}) addr_err <= addr_err + 1;
                        end
                        8'h40: begin pend <= 2'd2; smode <= 1'b1; end
                        8'hFF: begin
                            smode <= 1'b0; n_resets <= n_resets + 1;
                            if (fl_addr != {cur_bank, 4'h0}) addr_err <= addr_err + 1;
                        end
                        default: ;
                    endcase
                end
            end
        end
        if (clr_ctr) begin
            n_prog <= 0; n_resets <= 0; n_stat_reads <= 0; bad_poll <= 0;
            addr_err <= 0; order_err <= 0; next_off <= 0;
        end
    end

    int tests = 0, fails = 0;

    task automatic check(input string req, input string what, input int act, input int exp_v);
        tests++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp_v);
        end
    endtask

    task automatic launch(input logic prog, input logic [1:0] b);
        @(negedge clk);
        clr_ctr = 1'b1; cur_bank = b;
        @(negedge clk);
        clr_ctr = 1'b0;
        start = 1'b1; op_prog = prog; bank = b;
        @(negedge clk);
        start = 1'b0;
        check("R10", "busy after start", int'(busy), 1);
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        check("R10", "done reached", int'(done), 1);
    endtask

    function automatic logic [7:0] pat(input int b, input int i, input int k);
        return 8'((i * 29 + b * 71 + k * 13 + 3) & 255);
    endfunction

    initial begin
        #(20 * 190000);
        fails++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int errs;
        logic [7:0] snap [0:BB-1];
        for (int i = 0; i < BB * NB; i++) fm[i] = 8'h5A;
        for (int i = 0; i < BB; i++) img[i] = 8'h00;
        cur_bank = 2'd0;
        repeat (3) @(negedge clk);
        check("R11", "busy reset", int'(busy), 0);
        check("R11", "done reset", int'(done), 0);
        check("R11", "fail reset", int'(fail), 0);
        check("R11", "status reset", int'(status_q), 0);
        check("R11", "strobes reset", int'(fl_we | fl_re), 0);
        rst = 1'b0;

        // Sweep: erase then program every bank with two patterns
        for (int k = 0; k < 2; k++) begin
            for (int b = 0; b < NB; b++) begin
                launch(1'b0, 2'(b));
                wait_done();
                check("R5", "erase pass", int'(fail), 0);
                check("R3", "erase status", int'(status_q), 8'h80);
                errs = 0;
                for (int i = 0; i < BB; i++) if (fm[b * BB + i] != 8'hFF) errs++;
                check("R5", "bank erased", errs, 0);
                check("R1", "erase cmd address", addr_err, 0);
                check("R2", "poll at base", bad_poll, 0);
                check("R4", "one reset", n_resets, 1);
                for (int i = 0; i < BB; i++) img[i] = pat(b, i, k);
                launch(1'b1, 2'(b));
                wait_done();
                check("R8", "program pass", int'(fail), 0);
                errs = 0;
                for (int i = 0; i < BB; i++) if (fm[b * BB + i] != pat(b, i, k)) errs++;
                check("R6", "bank programmed", errs, 0);
                check("R6", "ascending order", order_err, 0);
                check("R6", "program count", n_prog, BB);
                check("R2", "poll at base prog", bad_poll, 0);
                check("R4", "one reset prog", n_resets, 1);
            end
        end

        // Program fault on byte 5 of bank 3
        for (int i = 0; i < BB; i++) snap[i] = fm[3 * BB + i];
        for (int i = 0; i < BB; i++) img[i] = 8'hC3 ^ 8'(i);
        f_err_byte = 5;
        launch(1'b1, 2'd3);
        wait_done();
        f_err_byte = -1;
        check("R3", "fault fails", int'(fail), 1);
        check("R3", "fault status", int'(status_q), 8'h90);
        check("R7", "stop after fault", n_prog, 6);
        errs = 0;
        for (int i = 6; i < BB; i++) if (fm[3 * BB + i] != snap[i]) errs++;
        check("R7", "later bytes untouched", errs, 0);
        check("R4", "reset after fault", n_resets, 1);

        // Erase reports a fault bit
        f_erase_err = 1'b1;
        launch(1'b0, 2'd0);
        wait_done();
        f_erase_err = 1'b0;
        check("R3", "erase fault fails", int'(fail), 1);
        check("R3", "erase fault status", int'(status_q), 8'h88);
        check("R4", "reset after erase fault", n_resets, 1);

        // Stuck byte after erase
        f_stuck = 11;
        launch(1'b0, 2'd1);
        wait_done();
        f_stuck = -1;
        check("R5", "stuck byte fails", int'(fail), 1);
        check("R5", "stuck status ready", int'(status_q), 8'h80);

        // Corrupted programmed byte
        launch(1'b0, 2'd2);
        wait_done();
        for (int i = 0; i < BB; i++) img[i] = 8'(i * 17);
        f_corrupt = 9;
        launch(1'b1, 2'd2);
        wait_done();
        f_corrupt = -1;
        check("R8", "mismatch fails", int'(fail), 1);
        check("R8", "all bytes sent", n_prog, BB);

        // Poll timeout
        f_hang = 1'b1;
        timeout_lim = 8'd20;
        launch(1'b0, 2'd0);
        wait_done();
        f_hang = 1'b0;
        check("R9", "timeout fails", int'(fail), 1);
        check("R9", "timeout status", int'(status_q), 0);
        check("R9", "reads before timeout", n_stat_reads, 20);
        check("R4", "reset after timeout", n_resets, 1);
        timeout_lim = 8'd50;
        repeat (DLY + 2) @(negedge clk);

        // Start while busy is ignored; done held afterwards
        for (int i = 0; i < BB; i++) snap[i] = fm[2 * BB + i];
        launch(1'b0, 2'd1);
        repeat (2) @(negedge clk);
        start = 1'b1; op_prog = 1'b1; bank = 2'd2;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check("R10", "first op passes", int'(fail), 0);
        errs = 0;
        for (int i = 0; i < BB; i++) if (fm[2 * BB + i] != snap[i]) errs++;
        check("R10", "other bank untouched", errs, 0);
        check("R10", "single op resets", n_resets, 1);
        repeat (5) @(negedge clk);
        check("R10", "done held", int'(done), 1);
        check("R10", "fail held", int'(fail), 0);
        check("R10", "idle after done", int'(busy), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule